// File: doc/BRIEF.md
# Generalized Bit Reverse Unit

This unit permutes a 64-bit source operand by sending each source bit to a new position. The new position is the source index XORed with a control amount. One amount value can therefore swap neighbouring bits, pairs, nibbles, bytes, halfwords and words in any combination. The amount comes either from a register operand or from a short immediate. Only as many low bits are kept as the active width needs.

A word mode works on the low 32 bits only and clears the upper half of the result. Each result is paired with a four-bit condition field. The field classifies the full 64-bit result, read as a signed number, as negative, positive or zero. A request is presented with `in_valid`. The result and the condition field are registered and appear one clock later. They hold their values until the next request.

Top module: `gbr_unit`

## Requirements
- R1: When `use_imm` is 1 the amount is taken from `amt_imm`; when it is 0 the amount is taken from the low bits of `amt_reg`.
- R2: The selected amount is reduced modulo the active width. In doubleword mode (`word_mode`=0) 6 bits are kept; in word mode (`word_mode`=1) 5 bits are kept. All higher bits of `amt_reg` and `amt_imm` have no effect on the result.
- R3: In doubleword mode, for every i in 0..63, result bit (i XOR amount) equals source bit i.
- R4: In word mode, for every i in 0..31, result bit (i XOR amount) equals source bit i. Result bits 63..32 are zero, and source bits 63..32 have no effect.
- R5: The condition field `cond` is read from the registered 64-bit result as a signed number: bit 3 is set for less than zero, bit 2 for greater than zero, bit 1 for equal to zero, and bit 0 is always 0.
- R6: A request accepted with `in_valid`=1 at a rising edge appears on `result` and `cond` after that edge, with `out_valid`=1. `out_valid` is 0 after any edge where `in_valid` was 0.
- R7: While `rst_n` is 0, `out_valid`, `result` and `cond` are all zero.
- R8: An amount of 0 returns the source unchanged. An amount of 63 in doubleword mode reverses all 64 bits, and an amount of 31 in word mode reverses the low 32 bits.
- R9: A source of 0xFFFF_FFFF_0000_0000 in word mode with amount 6 gives a zero result, and `cond` equals 4'b0010.
- R10: `result` and `cond` keep their values across edges where `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src | input | 64 | Source operand to permute |
| amt_reg | input | 64 | Register operand supplying the amount |
| amt_imm | input | 6 | Immediate amount |
| use_imm | input | 1 | 1 selects the immediate, 0 selects the register |
| word_mode | input | 1 | 1 selects the 32-bit mode, 0 the 64-bit mode |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Permuted result |
| cond | output | 4 | Condition field {lt, gt, eq, 0} |

## Verification
The hardest cases to reach are those where the discarded amount bits and source bits must be shown to have no effect. This means `amt_reg` values whose upper bits are dense with ones, and word-mode sources whose upper half is non-zero. Random stimulus fills all 64 bits of both the source and the amount register, and mixes modes and amount sources freely. Directed cases add register amounts such as 0xFFFF_FFFF_FFFF_FFC1, the all-ones word-mode case that must give zero, and the full-reversal amounts.

// File: rtl/gbr_pkg.sv
package gbr_pkg;
  // Condition field layout, MSB first: less, greater, equal, reserved-zero.
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic rsvd;
  } gbr_cond_t;

  typedef enum logic {
    GBR_DWORD = 1'b0,
    GBR_WORD  = 1'b1
  } gbr_mode_t;

  // Signed classification of a result given its sign bit and zero flag.
  function automatic gbr_cond_t gbr_classify(input logic sign_bit, input logic is_zero);
    gbr_cond_t c;
    c.lt   = sign_bit;
    c.gt   = !sign_bit && !is_zero;
    c.eq   = is_zero;
    c.rsvd = 1'b0;
    return c;
  endfunction
endpackage

// File: rtl/gbr_amt_sel.sv
module gbr_amt_sel #(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = $clog2(DW)
) (
  input  logic [DW-1:0]       amt_reg,
  input  logic [AW-1:0]       amt_imm,
  input  logic                use_imm,
  input  gbr_pkg::gbr_mode_t  mode,
  output logic [AW-1:0]       amt
);
  logic [AW-1:0] raw_amt;

  always_comb begin
    raw_amt = use_imm ? amt_imm : amt_reg[AW-1:0];
    amt     = raw_amt;
    // Half-width mode keeps one bit fewer of the amount.
    if (mode == gbr_pkg::GBR_WORD) amt[AW-1] = 1'b0;
  end
endmodule

// File: rtl/gbr_butterfly.sv
module gbr_butterfly #(
  parameter int unsigned DW = 64,
  parameter int unsigned AW = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] amt,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] stg [AW+1];

  assign stg[0] = din;

  // Stage s swaps neighbouring groups of 2**s bits when amt[s] is set.
  for (genvar s = 0; s < AW; s++) begin : g_stage
    for (genvar i = 0; i < DW; i++) begin : g_bit
      assign stg[s+1][i] = amt[s] ? stg[s][i ^ (1 << s)] : stg[s][i];
    end
  end

  assign dout = stg[AW];

  // A permutation moves bits but never creates or loses them.
  always_comb begin
    assert_popcount_R3: assert ($countones(dout) == $countones(din))
      else $error("butterfly changed the number of set bits");
  end
endmodule

// File: rtl/gbr_flags.sv
module gbr_flags #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0]       value,
  output gbr_pkg::gbr_cond_t  flags
);
  logic sign_bit;
  logic is_zero;

  assign sign_bit = value[DW-1];
  assign is_zero  = (value == '0);
  assign flags    = gbr_pkg::gbr_classify(sign_bit, is_zero);
endmodule

// File: rtl/gbr_unit.sv
module gbr_unit #(
  parameter int unsigned DW = 64,
  localparam int unsigned AW = $clog2(DW),
  localparam int unsigned HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] src,
  input  logic [DW-1:0] amt_reg,
  input  logic [AW-1:0] amt_imm,
  input  logic          use_imm,
  input  logic          word_mode,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic [3:0]    cond
);
  import gbr_pkg::*;

  gbr_mode_t     mode;
  logic [AW-1:0] amt;
  logic [DW-1:0] src_eff;
  logic [DW-1:0] perm;
  gbr_cond_t     flags;

  logic          valid_q;
  logic          word_q;
  logic [DW-1:0] result_q;
  gbr_cond_t     cond_q;

  assign mode    = word_mode ? GBR_WORD : GBR_DWORD;
  assign src_eff = (mode == GBR_WORD) ? {{HW{1'b0}}, src[HW-1:0]} : src;

  gbr_amt_sel #(.DW(DW), .AW(AW)) u_amt (
    .amt_reg (amt_reg),
    .amt_imm (amt_imm),
    .use_imm (use_imm),
    .mode    (mode),
    .amt     (amt)
  );

  gbr_butterfly #(.DW(DW), .AW(AW)) u_perm (
    .din  (src_eff),
    .amt  (amt),
    .dout (perm)
  );

  gbr_flags #(.DW(DW)) u_flags (
    .value (perm),
    .flags (flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      word_q   <= 1'b0;
      result_q <= '0;
      cond_q   <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        word_q   <= word_mode;
        result_q <= perm;
        cond_q   <= flags;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign cond      = cond_q;

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid)
    else $error("request did not produce out_valid");

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(cond)))
    else $error("result changed without a request");

  assert_word_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && word_q) |-> (result[DW-1:HW] == '0))
    else $error("word mode left upper result bits set");

  assert_cond_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cond[1] == (result == '0) && cond[3] == result[DW-1] && cond[0] == 1'b0))
    else $error("condition field disagrees with result");
endmodule

// File: tb/gbr_unit_test.sv
`timescale 1ns/1ps
module gbr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] src = '0;
  logic [63:0] amt_reg = '0;
  logic [5:0]  amt_imm = '0;
  logic        use_imm = 1'b0;
  logic        word_mode = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic [3:0]  cond;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gbr_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
    .amt_reg(amt_reg), .amt_imm(amt_imm), .use_imm(use_imm),
    .word_mode(word_mode), .out_valid(out_valid), .result(result), .cond(cond)
  );

  function automatic logic [63:0] ref_perm(logic [63:0] s, logic [63:0] a, bit w);
    int width = w ? 32 : 64;
    int m = int'(a % 64'(width));
    logic [63:0] e = '0;
    for (int i = 0; i < width; i++)
      if (s[i]) e[i ^ m] = 1'b1;
    return e;
  endfunction

  function automatic logic [3:0] ref_cond(logic [63:0] r);
    longint sv = $signed(r);
    logic [3:0] c = 4'b0000;
    if (sv < 0) c[3] = 1'b1;
    else if (sv > 0) c[2] = 1'b1;
    else c[1] = 1'b1;
    return c;
  endfunction

  task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request, then check result, cond and out_valid one edge later.
  task automatic run_op(string req, logic [63:0] s, logic [63:0] ar, logic [5:0] ai,
                        bit ui, bit w);
    logic [63:0] amount = ui ? {58'b0, ai} : ar;
    logic [63:0] e = ref_perm(s, amount, w);
    @(negedge clk);
    src = s; amt_reg = ar; amt_imm = ai; use_imm = ui; word_mode = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check64(req, result, e);
    check64({req, " cond R5"}, {60'b0, cond}, {60'b0, ref_cond(e)});
    check64("R6 out_valid", {63'b0, out_valid}, 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held_r;
    logic [3:0]  held_c;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R7: reset state
    check64("R7 out_valid", {63'b0, out_valid}, 64'd0);
    check64("R7 result", result, 64'd0);
    check64("R7 cond", {60'b0, cond}, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // R8 identity and full reversals
    run_op("R8 identity", 64'h0123_4567_89AB_CDEF, 64'd0, 6'd0, 1'b0, 1'b0);
    run_op("R8 reverse64", 64'h0000_0000_0000_0001, 64'd0, 6'd63, 1'b1, 1'b0);
    run_op("R8 reverse32", 64'h0000_0000_0000_0003, 64'd31, 6'd0, 1'b0, 1'b1);
    // R9 word mode all-ones upper half with amount 6
    run_op("R9 zero", 64'hFFFF_FFFF_0000_0000, 64'd6, 6'd0, 1'b0, 1'b1);
    check64("R9 cond", {60'b0, cond}, 64'd2);
    // R2 upper amount bits ignored, both widths
    run_op("R2 dword high bits", 64'h8000_0000_0000_00F0, 64'hFFFF_FFFF_FFFF_FFC1, 6'd0, 1'b0, 1'b0);
    run_op("R2 word high bits", 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_FFFF_FFC1, 6'd0, 1'b0, 1'b1);
    run_op("R2 imm bit5 in word", 64'hDEAD_BEEF_1234_5678, 64'd0, 6'd33, 1'b1, 1'b1);
    // R1 immediate vs register selection with conflicting values
    run_op("R1 imm chosen", 64'h0000_0000_0000_00FF, 64'd32, 6'd8, 1'b1, 1'b0);
    run_op("R1 reg chosen", 64'h0000_0000_0000_00FF, 64'd32, 6'd8, 1'b0, 1'b0);
    // R4 upper source bits ignored in word mode
    run_op("R4 upper src ignored", 64'hA5A5_A5A5_0F0F_0F0F, 64'd5, 6'd0, 1'b0, 1'b1);
    // R5 negative result
    run_op("R5 negative", 64'h0000_0000_0000_0001, 64'd63, 6'd0, 1'b0, 1'b0);

    // R10 hold with changed inputs and no request
    held_r = result; held_c = cond;
    @(negedge clk);
    src = 64'h1111_2222_3333_4444; amt_reg = 64'd9; word_mode = 1'b0;
    @(negedge clk);
    check64("R10 result hold", result, held_r);
    check64("R10 cond hold", {60'b0, cond}, {60'b0, held_c});
    check64("R6 idle out_valid", {63'b0, out_valid}, 64'd0);

    // R3 / R4 random mix
    for (int k = 0; k < 400; k++) begin
      logic [63:0] s = {$urandom(), $urandom()};
      logic [63:0] ar = {$urandom(), $urandom()};
      logic [5:0]  ai = 6'($urandom());
      bit ui = 1'($urandom());
      bit w = 1'($urandom());
      run_op(w ? "R4 random word" : "R3 random dword", s, ar, ai, ui, w);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule